// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol core of a 128-byte serial memory that answers as a slave on a two-wire bus. It samples raw SCL and SDA through a synchroniser running on a fast system clock. It finds START and STOP conditions, checks the first byte of each transfer against a fixed device code and three strap inputs, and drives only an open-drain pull-down enable for SDA. Byte writes, page writes, current-address reads, random reads and sequential reads are all served through one internal address pointer, which persists between transfers. Written bytes go out as strobes to a page-buffer/commit block. A commit pulse starts that block's internal write cycle. Read data comes back from the storage through a combinational address/data pair, and the commit block's busy flag silences the slave.

The controller has ten states. IDLE waits for a START. CTRL shifts in the control byte and then moves to CTRL_ACK on a match, or to IGNORE on a code mismatch, strap mismatch or busy. CTRL_ACK goes to ADDR for a write or to RD_BIT for a read. ADDR shifts the word address and goes to ADDR_ACK, which leads to WR_BIT. WR_BIT and WR_ACK alternate for each data byte. RD_BIT sends eight bits and goes to RD_ACK, which returns to RD_BIT when the master acknowledges and goes to IGNORE when it does not. IGNORE drives nothing. From every state, a START enters CTRL and a STOP enters IDLE.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START. From any state it restarts control-byte reception at bit 0 and releases SDA. A rising SDA while SCL is high is a STOP. It returns the slave to idle with SDA released.
- R2: The first byte after a START is decoded MSB first. Bits 7..4 must equal 1010 and bits 3..1 must equal strap_sel[2:0]. Bit 0 set to 1 selects a read and bit 0 set to 0 selects a write. Only a full match is acknowledged.
- R3: For every byte the addressed slave receives (control, word address, data), sda_oe is 1 throughout the high phase of the ninth SCL clock.
- R4: While busy is 1, a control byte that otherwise matches is not acknowledged, and the transfer is ignored.
- R5: In a write, the low 7 bits of the second byte load the pointer. Each later byte gives one wr_valid pulse carrying the pointer and the byte. After each such byte the low four pointer bits advance and wrap inside the 16-byte page, and the upper three bits are kept.
- R6: When a write that received at least one data byte ends with a STOP or a repeated START, commit pulses once. A write that carried only a word address does not pulse commit.
- R7: In a random read (a word address, then a repeated START, then a read control byte), the first byte returned is the one at the loaded address.
- R8: A read control byte with no preceding address returns the byte at the pointer, which is one past the last location accessed.
- R9: If the master acknowledges a read byte, the next sequential byte follows. If it does not, the slave drives nothing until the next START or STOP.
- R10: After each read byte the pointer increases by one and wraps from 127 to 0.
- R11: Read data leaves MSB first. sda_oe changes only while the synchronised SCL is low. It is 0 during the master's acknowledge slot.
- R12: After a control byte that does not match, sda_oe stays 0 until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level |
| strap_sel | input | 3 | Chip-select straps compared with control bits 3..1 |
| busy | input | 1 | Internal write cycle in progress |
| rd_data | input | 8 | Storage byte at rd_addr |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_addr | output | 7 | Current pointer, used as the read address |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 7 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| commit | output | 1 | One-cycle pulse that starts the write cycle |

## Verification
The bench writes a page that starts two bytes below a page end. A design that carried into the upper pointer bits would strobe 0x20 instead of wrapping to 0x10. It also reads sequentially across address 127, where a pointer without wrap-around would return the wrong byte. The bench polls immediately after a commit, so a slave that ignored busy would acknowledge too early. A random read that follows an address-only write must leave the commit count unchanged, or a spurious write cycle would start. Control bytes that fail on the strap bits or on the device code must leave sda_oe at 0 through the following byte. Then a current-address read must show that the pointer was not disturbed.

// File: rtl/eep_slave_pkg.sv
package eep_slave_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BIT,
        ST_WR_ACK,
        ST_RD_BIT,
        ST_RD_ACK,
        ST_IGNORE
    } slave_state_t;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_raw;
                    sda_pipe <= sda_raw;
                end
            end
        end
    endgenerate

    assign scl_lvl = scl_pipe[STAGES-1];
    assign sda_lvl = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/eep_ptr_unit.sv
module eep_ptr_unit #(
    parameter int AW = 7,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_seq,
    input  logic          step_page,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] seq_next;
    logic [AW-1:0] page_next;

    assign seq_next = ptr + 1'b1;

    generate
        if (PW < AW) begin : g_paged
            assign page_next = {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
        end else begin : g_flat
            assign page_next = seq_next;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ptr <= '0;
        else if (load)      ptr <= load_val;
        else if (step_page) ptr <= page_next;
        else if (step_seq)  ptr <= seq_next;
    end

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eep_slave_pkg::*;
#(
    parameter int MEM_BYTES   = 128,
    parameter int PAGE_BYTES  = 16,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_in,
    input  logic                          sda_in,
    input  logic [SEL_W-1:0]              strap_sel,
    input  logic                          busy,
    input  logic [BYTE_W-1:0]             rd_data,
    output logic                          sda_oe,
    output logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
    output logic                          wr_valid,
    output logic [$clog2(MEM_BYTES)-1:0]  wr_addr,
    output logic [BYTE_W-1:0]             wr_data,
    output logic                          commit
);
    localparam int AW    = $clog2(MEM_BYTES);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(BYTE_W);

    slave_state_t state, state_nx;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] byte_in;
    logic [CNT_W-1:0]  bit_cnt;
    logic              last_bit;
    logic              slot;
    logic              rw_q;
    logic              mack_q;
    logic              pend_q;
    logic              oe_q;
    logic              ctrl_hit;
    logic              ptr_load, ptr_seq, ptr_page;
    logic [AW-1:0]     ptr;
    logic              in_ignore;
    logic              bus_evt;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_lvl   (scl_s),
        .sda_lvl   (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_in  = {shreg[BYTE_W-2:0], sda_s};
    assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign bus_evt  = start_det | stop_det;
    assign ctrl_hit = (byte_in[7:4] == DEV_CODE) &&
                      (byte_in[SEL_W:1] == strap_sel) && !busy;

    assign ptr_load = !bus_evt && (state == ST_ADDR) && scl_rise && last_bit;
    assign ptr_page = !bus_evt && (state == ST_WR_BIT) && scl_rise && last_bit;
    assign ptr_seq  = !bus_evt && (state == ST_RD_BIT) && scl_fall && last_bit;

    eep_ptr_unit #(.AW(AW), .PW(PW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_val  (byte_in[AW-1:0]),
        .step_seq  (ptr_seq),
        .step_page (ptr_page),
        .ptr       (ptr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_CTRL;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_CTRL:
                    if (scl_rise && last_bit)
                        state_nx = ctrl_hit ? ST_CTRL_ACK : ST_IGNORE;
                ST_CTRL_ACK:
                    if (scl_fall && slot)
                        state_nx = rw_q ? ST_RD_BIT : ST_ADDR;
                ST_ADDR:
                    if (scl_rise && last_bit) state_nx = ST_ADDR_ACK;
                ST_ADDR_ACK:
                    if (scl_fall && slot) state_nx = ST_WR_BIT;
                ST_WR_BIT:
                    if (scl_rise && last_bit) state_nx = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall && slot) state_nx = ST_WR_BIT;
                ST_RD_BIT:
                    if (scl_fall && last_bit) state_nx = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) state_nx = mack_q ? ST_RD_BIT : ST_IGNORE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            slot     <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            pend_q   <= 1'b0;
            oe_q     <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            commit   <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            commit   <= 1'b0;
            if (bus_evt) begin
                oe_q    <= 1'b0;
                bit_cnt <= '0;
                slot    <= 1'b0;
                pend_q  <= 1'b0;
                if (pend_q) commit <= 1'b1;
            end else begin
                unique case (state)
                    ST_CTRL, ST_ADDR, ST_WR_BIT: begin
                        if (scl_rise) begin
                            shreg   <= byte_in;
                            bit_cnt <= bit_cnt + 1'b1;
                            slot    <= 1'b0;
                            if (last_bit && state == ST_CTRL) rw_q <= byte_in[0];
                            if (last_bit && state == ST_WR_BIT) begin
                                wr_valid <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= byte_in;
                                pend_q   <= 1'b1;
                            end
                        end
                    end
                    ST_CTRL_ACK, ST_ADDR_ACK, ST_WR_ACK: begin
                        if (scl_fall) begin
                            if (!slot) begin
                                slot <= 1'b1;
                                oe_q <= 1'b1;
                            end else begin
                                slot    <= 1'b0;
                                bit_cnt <= '0;
                                oe_q    <= 1'b0;
                                if (state == ST_CTRL_ACK && rw_q) begin
                                    shreg <= rd_data;
                                    oe_q  <= ~rd_data[BYTE_W-1];
                                end
                            end
                        end
                    end
                    ST_RD_BIT: begin
                        if (scl_fall) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                oe_q   <= 1'b0;
                                mack_q <= 1'b0;
                            end else begin
                                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                                oe_q  <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        if (scl_fall && mack_q) begin
                            shreg   <= rd_data;
                            oe_q    <= ~rd_data[BYTE_W-1];
                            bit_cnt <= '0;
                        end
                    end
                    ST_IDLE, ST_IGNORE: oe_q <= 1'b0;
                    default: oe_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe    = oe_q;
    assign rd_addr   = ptr;
    assign in_ignore = (state == ST_IGNORE);

endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic scl_lvl,
    input logic start_det,
    input logic stop_det,
    input logic busy,
    input logic commit,
    input logic wr_valid,
    input logic ignoring
);
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    p_commit_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(start_det || stop_det));

    p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !$rose(sda_oe));

    p_ignore_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ignoring |-> !sda_oe);

    p_strobe_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !sda_oe);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, commit}));

    p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

bind eeprom_i2c_slave eep_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_lvl   (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy      (busy),
    .commit    (commit),
    .wr_valid  (wr_valid),
    .ignoring  (in_ignore)
);

// File: tb/eeprom_i2c_slave_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_tb;
    localparam int HALF     = 10;
    localparam int BUSY_CYC = 600;
    localparam logic [2:0] SEL = 3'b101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       busy = 1'b0;
    logic [7:0] rd_data;
    logic       sda_oe, wr_valid, commit;
    logic [6:0] rd_addr, wr_addr;
    logic [7:0] wr_data;

    logic [7:0]  mem     [128];
    logic [7:0]  exp_mem [128];
    logic [14:0] wq[$];
    logic [14:0] pg_q[$];
    int          n_cmp = 0, n_bad = 0, ncommit = 0, busy_cnt = 0;
    logic        oe_seen = 1'b0;
    logic [6:0]  exp_ptr = 7'd0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[rd_addr];

    eeprom_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .strap_sel(SEL), .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe),
        .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard of write strobes and model of the commit block
    always @(negedge clk) begin
        if (sda_oe) oe_seen = 1'b1;
        if (wr_valid) begin
            pg_q.push_back({wr_addr, wr_data});
            if (wq.size() == 0) chk("R5 unexpected strobe", {wr_addr, wr_data}, 0);
            else chk("R5 write strobe", {wr_addr, wr_data}, wq.pop_front());
        end
        if (commit) begin
            ncommit++;
            foreach (pg_q[k]) mem[pg_q[k][14:8]] = pg_q[k][7:0];
            pg_q.delete();
            busy_cnt = BUSY_CYC;
        end
        if (busy_cnt > 0) busy_cnt--;
        busy = (busy_cnt != 0);
    end

    task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; cyc(HALF); scl = 1'b1; cyc(HALF);
        sda_m = 1'b0; cyc(HALF); scl = 1'b0; cyc(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; cyc(HALF); scl = 1'b1; cyc(HALF); sda_m = 1'b1; cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; cyc(HALF); scl = 1'b1; cyc(HALF); scl = 1'b0; cyc(2);
        end
        sda_m = 1'b1; cyc(HALF); scl = 1'b1; cyc(HALF/2);
        acked = (sda_line == 1'b0);
        cyc(HALF/2); scl = 1'b0; cyc(2);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b, output logic oe_slot);
        for (int i = 7; i >= 0; i--) begin
            cyc(HALF); scl = 1'b1; cyc(HALF/2); b[i] = sda_line;
            cyc(HALF/2); scl = 1'b0; cyc(2);
        end
        sda_m = mack ? 1'b0 : 1'b1; cyc(HALF); scl = 1'b1; cyc(HALF/2);
        oe_slot = sda_oe;
        cyc(HALF/2); scl = 1'b0; cyc(2); sda_m = 1'b1;
    endtask

    task automatic wait_ready();
        logic ack;
        bus_start(); send_byte({4'b1010, SEL, 1'b0}, ack); bus_stop();
        chk("R4 poll while busy", ack, 0);
        for (int p = 0; p < 60 && !ack; p++) begin
            bus_start(); send_byte({4'b1010, SEL, 1'b0}, ack); bus_stop();
        end
        chk("R4 ack after write cycle", ack, 1);
    endtask

    task automatic do_write(input logic [6:0] a, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] d [3];
        logic       ack;
        logic [6:0] p;
        int         c0;
        d = '{d0, d1, d2};
        c0 = ncommit;
        p = a;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0}, ack); chk("R2 write control ack", ack, 1);
        send_byte({1'b0, a}, ack);           chk("R3 address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            wq.push_back({p, d[k]});
            exp_mem[p] = d[k];
            p = {p[6:4], p[3:0] + 4'd1};
            send_byte(d[k], ack); chk("R3 data ack", ack, 1);
        end
        bus_stop();
        exp_ptr = p;
        chk("R6 one commit per write", ncommit - c0, 1);
        wait_ready();
    endtask

    task automatic do_read(input logic random, input logic [6:0] a, input int n, input string req);
        logic       ack, oe_slot;
        logic [7:0] b;
        int         c0;
        c0 = ncommit;
        bus_start();
        if (random) begin
            send_byte({4'b1010, SEL, 1'b0}, ack); chk("R2 write control ack", ack, 1);
            send_byte({1'b0, a}, ack);           chk("R3 address ack", ack, 1);
            bus_start();
            exp_ptr = a;
        end
        send_byte({4'b1010, SEL, 1'b1}, ack); chk("R2 read control ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b, oe_slot);
            chk(req, b, exp_mem[exp_ptr]);
            chk("R11 released in master ack slot", oe_slot, 0);
            exp_ptr = exp_ptr + 7'd1;
        end
        oe_seen = 1'b0;
        cyc(HALF);
        chk("R9 no drive after master nack", oe_seen, 0);
        bus_stop();
        chk("R6 no commit on read", ncommit - c0, 0);
    endtask

    task automatic bad_ctrl(input logic [7:0] cb, input string req);
        logic ack;
        logic [7:0] dummy;
        logic slot;
        bus_start();
        oe_seen = 1'b0;
        send_byte(cb, ack);
        chk(req, ack, 0);
        recv_byte(1'b1, dummy, slot);
        chk("R12 silent after mismatch", oe_seen, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]     = 8'((i * 37 + 5) & 255);
            exp_mem[i] = 8'((i * 37 + 5) & 255);
        end
        cyc(5);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R5 reset wr_valid", wr_valid, 0);
        chk("R6 reset commit", commit, 0);
        rst_n = 1'b1;
        cyc(5);

        do_write(7'h10, 1, 8'hA5, 8'h00, 8'h00);                  // R5 byte write
        do_read(1'b1, 7'h10, 1, "R7 random read");
        do_read(1'b0, 7'h00, 2, "R8 current-address read");       // R9 sequential
        do_write(7'h1E, 3, 8'h11, 8'h22, 8'h33);                  // R5 page wrap
        do_read(1'b1, 7'h1E, 2, "R9 sequential read");
        do_read(1'b1, 7'h10, 1, "R5 page wrap readback");
        do_read(1'b1, 7'h7E, 3, "R10 pointer wrap");
        do_read(1'b0, 7'h00, 1, "R10 pointer after wrap");
        bad_ctrl({4'b1010, 3'b100, 1'b1}, "R2 strap mismatch no ack");
        do_read(1'b0, 7'h00, 1, "R1 repeated start after mismatch");
        bad_ctrl({4'b1011, SEL, 1'b0}, "R2 code mismatch no ack");
        bus_stop();
        do_read(1'b0, 7'h00, 1, "R12 pointer untouched");

        chk("R5 strobe queue drained", wq.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(190000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule